// File: doc/BRIEF.md
# Command/Response Buffer Device Controller

This block is the device end of a memory-mapped command/response channel. A host reaches it over a plain 32-bit register bus. The address space has two parts. The first is a small control area with doorbells, status, interrupt control and buffer geometry. The second is a shared buffer that holds the command on the way in and the response on the way out. The host raises a doorbell bit to ask for something. The device lowers that bit itself once the action has been carried out.

Before each transaction the host wakes the device with a command-ready doorbell. It then writes a command into the shared buffer, clears the cancel bit and sets the start doorbell. A stub processing engine waits a configurable number of cycles and then overwrites the buffer with a 10-byte response: the command's first two bytes, a big-endian length and a big-endian return code. The start bit falling back to zero tells the host the response is ready. The host may set the cancel bit to cut a running command short, or send the device to idle with a go-idle doorbell.

Top module: `cmdbuf_ctrl`

## Requirements
- R1: After reset the request (0x00), start (0x0C), cancel (0x08) and interrupt status (0x14) registers read 0, the status register (0x04) reads 2 (bit 1 idle set, bit 0 error clear), and `irq` is low.
- R2: The command size (0x18) and response size (0x24) both read 4*BUF_WORDS bytes. The command address (low 0x1C, high 0x20) and the response address (low 0x28, high 0x2C) both read HOST_BASE+0x80. Writes to these six registers have no effect.
- R3: Writing a value with bit 0 set to 0x00 sets request bit 0. The device clears that bit within WAKE_CYC+1 cycles, after which status bit 1 reads 0.
- R4: Writing a value with bit 1 set (bit 0 clear) to 0x00 sets request bit 1. While a command is still running, the bit stays set and the status keeps idle clear. Once the command ends and the idle transition completes, the bit clears and status bit 1 reads 1.
- R5: A command-ready request written while a go-idle is still pending wins. Both request bits then clear and the device ends ready, with status bit 1 at 0.
- R6: Writing bit 0 of start (0x0C) while the device is ready and idle of work sets start bit 0. The bit stays set for exactly LATENCY+3 cycles when no cancel arrives.
- R7: The response overwrites buffer words 0..2 (byte k of the buffer sits in word k/4, bits 8*(k%4)+7 down to 8*(k%4)). Bytes 0-1 are copied from the command. Bytes 2-5 hold 10 big-endian. Bytes 6-9 hold the return code big-endian (0 on success). Bytes 10-11 are 0.
- R8: With cancel bit 0 set when the command starts, start clears after exactly 4 cycles. With cancel set while the command runs, start clears within 5 cycles. In both cases the return code is RC_CANCELLED (0x00000901). The cancel bit keeps its value until the host writes it.
- R9: A start write while the device is not ready sets status bit 0 (error), leaves start at 0 and leaves the buffer unchanged. The next completed command-ready clears the error bit.
- R10: Completion sets interrupt status bit 0. `irq` equals interrupt enable bit 0 (0x10) AND interrupt status bit 0. Writing 1 to bit 0 of 0x14 clears the status bit.
- R11: Word-aligned addresses from 0x80 up to 0x80+4*BUF_WORDS-1 read and write the shared buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register/buffer write strobe |
| bus_addr | input | 8 | Byte address (word aligned) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed location, combinational |
| irq | output | 1 | Completion interrupt |

## Verification
The main function is driven from a table of commands with varied tag bytes. Each entry either has cancel clear or has it already set at start. A clear-cancel entry confirms that the tag bytes are copied and that the success code and full LATENCY+3 busy window appear. A set-cancel entry tells the early-abort path apart by its four-cycle window and its cancelled return code. Directed cases then cover these situations:
- a cancel raised in the middle of a run;
- a start written while the device is idle;
- a go-idle held off by a running command;
- a command-ready that overtakes a pending go-idle.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;

  // Control-area word indices (byte offset / 4)
  localparam logic [4:0] IX_REQ      = 5'd0;
  localparam logic [4:0] IX_STS      = 5'd1;
  localparam logic [4:0] IX_CANCEL   = 5'd2;
  localparam logic [4:0] IX_START    = 5'd3;
  localparam logic [4:0] IX_INTEN    = 5'd4;
  localparam logic [4:0] IX_INTSTS   = 5'd5;
  localparam logic [4:0] IX_CSIZE    = 5'd6;
  localparam logic [4:0] IX_CADDR_LO = 5'd7;
  localparam logic [4:0] IX_CADDR_HI = 5'd8;
  localparam logic [4:0] IX_RSIZE    = 5'd9;
  localparam logic [4:0] IX_RADDR_LO = 5'd10;
  localparam logic [4:0] IX_RADDR_HI = 5'd11;

  localparam logic [7:0] RSP_LEN = 8'd10;

  typedef enum logic [1:0] {PW_IDLE, PW_WAKE, PW_READY, PW_SLEEP} pw_state_t;
  typedef enum logic [2:0] {EN_IDLE, EN_RUN, EN_W0, EN_W1, EN_W2} en_state_t;

  // Response word 0: tag bytes 0-1, length bytes 2-3 (upper half of BE length, zero)
  function automatic logic [31:0] rsp_word0(input logic [15:0] tag);
    return {16'h0000, tag};
  endfunction

  // Response word 1: length bytes 4-5, return-code bytes 6-7
  function automatic logic [31:0] rsp_word1(input logic [31:0] rc);
    return {rc[23:16], rc[31:24], RSP_LEN, 8'h00};
  endfunction

  // Response word 2: return-code bytes 8-9, padding bytes 10-11
  function automatic logic [31:0] rsp_word2(input logic [31:0] rc);
    return {16'h0000, rc[7:0], rc[15:8]};
  endfunction

endpackage

// File: rtl/cbuf_ram.sv
module cbuf_ram #(
  parameter int WORDS = 16,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             host_we,
  input  logic [IDX_W-1:0] host_idx,
  input  logic [31:0]      host_wdata,
  output logic [31:0]      host_rdata,
  input  logic             eng_we,
  input  logic [IDX_W-1:0] eng_idx,
  input  logic [31:0]      eng_wdata,
  output logic [15:0]      tag_o
);
  logic [31:0] mem [WORDS];

  // Engine write is placed last so it wins a same-word collision
  always_ff @(posedge clk) begin
    if (host_we) mem[host_idx] <= host_wdata;
    if (eng_we)  mem[eng_idx]  <= eng_wdata;
  end

  assign host_rdata = mem[host_idx];
  assign tag_o      = mem[0][15:0];
endmodule

// File: rtl/cbuf_power.sv
module cbuf_power
  import cbuf_pkg::*;
#(
  parameter int WAKE_CYC = 4,
  parameter int IDLE_CYC = 3,
  localparam int MAXC = (WAKE_CYC > IDLE_CYC) ? WAKE_CYC : IDLE_CYC,
  localparam int CW   = $clog2(MAXC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ready,
  input  logic set_idle,
  input  logic busy,
  output logic pend_ready,
  output logic pend_idle,
  output logic dev_ready,
  output logic dev_idle,
  output logic ready_ack
);
  pw_state_t st;
  logic [CW-1:0] cnt;

  assign ready_ack = (st == PW_WAKE) && (cnt == '0);
  assign dev_ready = (st == PW_READY);
  assign dev_idle  = (st == PW_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= PW_IDLE; cnt <= '0; pend_ready <= 1'b0; pend_idle <= 1'b0;
    end else if (set_ready) begin
      pend_ready <= 1'b1;
      pend_idle  <= 1'b0;
      if (st != PW_WAKE) begin
        st  <= PW_WAKE;
        cnt <= CW'(WAKE_CYC - 1);
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        st <= PW_READY; pend_ready <= 1'b0;
      end
    end else if (set_idle) begin
      pend_idle  <= 1'b1;
      pend_ready <= 1'b0;
      st  <= PW_SLEEP;
      cnt <= CW'(IDLE_CYC - 1);
    end else begin
      case (st)
        PW_WAKE:
          if (cnt == '0) begin st <= PW_READY; pend_ready <= 1'b0; end
          else cnt <= cnt - 1'b1;
        PW_SLEEP:
          if (!busy) begin
            if (cnt == '0) begin st <= PW_IDLE; pend_idle <= 1'b0; end
            else cnt <= cnt - 1'b1;
          end
        default: ;
      endcase
    end
  end

  // Cycles a command-ready request has been outstanding
  logic [CW:0] wait_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)          wait_cnt <= '0;
    else if (pend_ready) wait_cnt <= wait_cnt + 1'b1;
    else                 wait_cnt <= '0;
  end

  // R3
  wake_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= (CW+1)'(WAKE_CYC));

  // R5
  ready_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_ready |=> (!pend_idle && (st == PW_WAKE || st == PW_READY)));

  // R4
  idle_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PW_SLEEP && busy && !set_ready) |=> (st == PW_SLEEP));
endmodule

// File: rtl/cbuf_engine.sv
module cbuf_engine
  import cbuf_pkg::*;
#(
  parameter int          LATENCY      = 20,
  parameter logic [31:0] RC_CANCELLED = 32'h0000_0901,
  parameter int          IDX_W        = 4,
  localparam int         CNT_W        = $clog2(LATENCY + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             abort,
  input  logic [15:0]      tag_in,
  output logic             busy,
  output logic             done,
  output logic             mem_we,
  output logic [IDX_W-1:0] mem_idx,
  output logic [31:0]      mem_wdata
);
  en_state_t st;
  logic [CNT_W-1:0] cnt;
  logic [15:0] tag_q;
  logic [31:0] rc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= EN_IDLE; cnt <= '0; tag_q <= '0; rc_q <= '0;
    end else begin
      case (st)
        EN_IDLE:
          if (go) begin
            st <= EN_RUN; cnt <= CNT_W'(LATENCY - 1); tag_q <= tag_in; rc_q <= '0;
          end
        EN_RUN:
          if (abort) begin
            rc_q <= RC_CANCELLED; st <= EN_W0;
          end else if (cnt == '0) begin
            st <= EN_W0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        EN_W0:   st <= EN_W1;
        EN_W1:   st <= EN_W2;
        default: st <= EN_IDLE;
      endcase
    end
  end

  assign busy = (st != EN_IDLE);
  assign done = (st == EN_W2);

  always_comb begin
    mem_we    = 1'b0;
    mem_idx   = '0;
    mem_wdata = '0;
    case (st)
      EN_W0: begin mem_we = 1'b1; mem_idx = IDX_W'(0); mem_wdata = rsp_word0(tag_q); end
      EN_W1: begin mem_we = 1'b1; mem_idx = IDX_W'(1); mem_wdata = rsp_word1(rc_q);  end
      EN_W2: begin mem_we = 1'b1; mem_idx = IDX_W'(2); mem_wdata = rsp_word2(rc_q);  end
      default: ;
    endcase
  end

  // R6
  go_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (st == EN_IDLE));

  // R8
  abort_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == EN_RUN && abort) |=> (st == EN_W0 && rc_q == RC_CANCELLED));
endmodule

// File: rtl/cmdbuf_ctrl.sv
module cmdbuf_ctrl
  import cbuf_pkg::*;
#(
  parameter int          BUF_WORDS    = 16,
  parameter int          LATENCY      = 20,
  parameter int          WAKE_CYC     = 4,
  parameter int          IDLE_CYC     = 3,
  parameter logic [63:0] HOST_BASE    = 64'h0000_0000_FED4_0000,
  parameter logic [31:0] RC_CANCELLED = 32'h0000_0901,
  localparam int          ADDR_W    = 8,
  localparam int          IDX_W     = $clog2(BUF_WORDS),
  localparam logic [31:0] BUF_BYTES = 32'(4 * BUF_WORDS),
  localparam logic [63:0] BUF_ADDR  = HOST_BASE + 64'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  // Address decode
  logic       aligned, ctrl_sel, buf_sel;
  logic [4:0] word_ix;
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign word_ix  = bus_addr[6:2];
  assign ctrl_sel = aligned && !bus_addr[7];
  assign buf_sel  = aligned && bus_addr[7] && (32'(word_ix) < 32'(BUF_WORDS));

  function automatic logic hit(input logic [4:0] ix);
    return bus_wr && ctrl_sel && (word_ix == ix);
  endfunction

  // Internal events brought out for assertions
  logic set_ready, set_idle, start_wr, go, abort_now;
  logic eng_done, eng_busy;
  logic pend_ready, pend_idle, dev_ready, dev_idle, ready_ack;

  logic start_q, cancel_q, int_en_q, int_sts_q, err_q;

  assign set_ready = hit(IX_REQ) && bus_wdata[0];
  assign set_idle  = hit(IX_REQ) && bus_wdata[1] && !bus_wdata[0];
  assign start_wr  = hit(IX_START) && bus_wdata[0];
  assign go        = start_wr && dev_ready && !start_q;
  assign abort_now = cancel_q;

  cbuf_power #(.WAKE_CYC(WAKE_CYC), .IDLE_CYC(IDLE_CYC)) power_i (
    .clk(clk), .rst_n(rst_n), .set_ready(set_ready), .set_idle(set_idle),
    .busy(eng_busy), .pend_ready(pend_ready), .pend_idle(pend_idle),
    .dev_ready(dev_ready), .dev_idle(dev_idle), .ready_ack(ready_ack)
  );

  logic             eng_we;
  logic [IDX_W-1:0] eng_idx;
  logic [31:0]      eng_wdata, buf_rdata;
  logic [15:0]      cmd_tag;

  cbuf_engine #(.LATENCY(LATENCY), .RC_CANCELLED(RC_CANCELLED), .IDX_W(IDX_W)) engine_i (
    .clk(clk), .rst_n(rst_n), .go(go), .abort(abort_now), .tag_in(cmd_tag),
    .busy(eng_busy), .done(eng_done), .mem_we(eng_we), .mem_idx(eng_idx),
    .mem_wdata(eng_wdata)
  );

  cbuf_ram #(.WORDS(BUF_WORDS)) ram_i (
    .clk(clk), .host_we(bus_wr && buf_sel), .host_idx(word_ix[IDX_W-1:0]),
    .host_wdata(bus_wdata), .host_rdata(buf_rdata),
    .eng_we(eng_we), .eng_idx(eng_idx), .eng_wdata(eng_wdata), .tag_o(cmd_tag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0; cancel_q <= 1'b0; int_en_q <= 1'b0;
      int_sts_q <= 1'b0; err_q <= 1'b0;
    end else begin
      if (eng_done)  start_q <= 1'b0;
      else if (go)   start_q <= 1'b1;

      if (ready_ack)                            err_q <= 1'b0;
      else if (start_wr && !dev_ready && !start_q) err_q <= 1'b1;

      if (hit(IX_CANCEL)) cancel_q <= bus_wdata[0];
      if (hit(IX_INTEN))  int_en_q <= bus_wdata[0];

      if (eng_done)                             int_sts_q <= 1'b1;
      else if (hit(IX_INTSTS) && bus_wdata[0])  int_sts_q <= 1'b0;
    end
  end

  assign irq = int_en_q && int_sts_q;

  always_comb begin
    bus_rdata = '0;
    if (buf_sel) begin
      bus_rdata = buf_rdata;
    end else if (ctrl_sel) begin
      case (word_ix)
        IX_REQ:      bus_rdata = {30'b0, pend_idle, pend_ready};
        IX_STS:      bus_rdata = {30'b0, dev_idle, err_q};
        IX_CANCEL:   bus_rdata = {31'b0, cancel_q};
        IX_START:    bus_rdata = {31'b0, start_q};
        IX_INTEN:    bus_rdata = {31'b0, int_en_q};
        IX_INTSTS:   bus_rdata = {31'b0, int_sts_q};
        IX_CSIZE,
        IX_RSIZE:    bus_rdata = BUF_BYTES;
        IX_CADDR_LO,
        IX_RADDR_LO: bus_rdata = BUF_ADDR[31:0];
        IX_CADDR_HI,
        IX_RADDR_HI: bus_rdata = BUF_ADDR[63:32];
        default:     bus_rdata = '0;
      endcase
    end
  end

  // R6
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start_q) |-> $past(eng_done));

  // R9
  start_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && !dev_ready && !start_q && !ready_ack) |=> (err_q && !start_q));

  // R10
  int_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_sts_q) |-> $past(eng_done));
endmodule

// File: tb/cmdbuf_ctrl_tb_top.sv
module cmdbuf_ctrl_tb_top;
  localparam int          LAT  = 20;
  localparam int          WAKE = 4;
  localparam logic [31:0] RCC  = 32'h0000_0901;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, irq;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  cmdbuf_ctrl #(.BUF_WORDS(16), .LATENCY(LAT), .WAKE_CYC(WAKE), .IDLE_CYC(3),
                .HOST_BASE(64'h0000_0000_FED4_0000), .RC_CANCELLED(RCC)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // Bit 32: cancel already set at start; bits 31:0: command word 0
  localparam logic [32:0] VEC [0:5] = '{
    33'h0_DEAD_8001, 33'h0_0000_C280, 33'h1_FFFF_8002,
    33'h0_1234_0000, 33'h1_0000_0001, 33'h0_A5A5_5A5A
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  // Number of cycles start reads 1, sampled once per cycle
  task automatic start_window(input int limit, output int n);
    logic [31:0] v;
    n = 0;
    forever begin
      rd(8'h0C, v);
      if (v[0] == 1'b0 || n >= limit) break;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_req_clear(input int limit, output int n);
    logic [31:0] v;
    n = 0;
    forever begin
      rd(8'h00, v);
      if (v[1:0] == 2'b00 || n >= limit) break;
      n++;
      @(negedge clk);
    end
  endtask

  // Expected response word built byte by byte
  function automatic logic [31:0] exp_word(input int w, input logic [15:0] tag, input logic [31:0] rc);
    logic [7:0] b [12];
    foreach (b[i]) b[i] = 8'h00;
    b[0] = tag[7:0]; b[1] = tag[15:8];
    b[5] = 8'd10;
    b[6] = rc[31:24]; b[7] = rc[23:16]; b[8] = rc[15:8]; b[9] = rc[7:0];
    return {b[4*w+3], b[4*w+2], b[4*w+1], b[4*w]};
  endfunction

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual %h expected %h", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, v); check("R1 req", v, 0);
    rd(8'h04, v); check("R1 sts", v, 2);
    rd(8'h0C, v); check("R1 start", v, 0);
    rd(8'h08, v); check("R1 cancel", v, 0);
    rd(8'h14, v); check("R1 intsts", v, 0);
    check("R1 irq", {31'b0, irq}, 0);

    // R2 geometry registers, read-only
    rd(8'h18, v); check("R2 cmd size", v, 64);
    rd(8'h24, v); check("R2 rsp size", v, 64);
    rd(8'h1C, v); check("R2 cmd lo", v, 32'hFED4_0080);
    rd(8'h20, v); check("R2 cmd hi", v, 0);
    rd(8'h28, v); check("R2 rsp lo", v, 32'hFED4_0080);
    rd(8'h2C, v); check("R2 rsp hi", v, 0);
    @(negedge clk);
    wr(8'h18, 32'h1); wr(8'h28, 32'h0);
    rd(8'h18, v); check("R2 size write ignored", v, 64);
    rd(8'h28, v); check("R2 addr write ignored", v, 32'hFED4_0080);

    // R11 shared buffer access
    @(negedge clk);
    wr(8'h94, 32'hCAFE_F00D); wr(8'hBC, 32'h0BAD_BEEF); wr(8'h80, 32'h1234_ABCD);
    rd(8'h94, v); check("R11 word5", v, 32'hCAFE_F00D);
    rd(8'hBC, v); check("R11 word15", v, 32'h0BAD_BEEF);

    // R9 start while idle
    @(negedge clk);
    wr(8'h0C, 1);
    rd(8'h0C, v); check("R9 start refused", v, 0);
    rd(8'h04, v); check("R9 error set", v, 3);
    rd(8'h80, v); check("R9 buffer untouched", v, 32'h1234_ABCD);

    // R3 command-ready handshake
    @(negedge clk);
    wr(8'h00, 1);
    wait_req_clear(20, n);
    check("R3 ack bound", {31'b0, n <= WAKE + 1}, 1);
    rd(8'h04, v); check("R3/R9 ready, error cleared", v, 0);

    // Main function: table of commands
    @(negedge clk);
    wr(8'h10, 1);
    for (int i = 0; i < 6; i++) begin
      logic cxl;
      logic [31:0] rc;
      cxl = VEC[i][32];
      rc  = cxl ? RCC : 32'h0;
      @(negedge clk);
      wr(8'h08, {31'b0, cxl});
      wr(8'h80, VEC[i][31:0]);
      wr(8'h0C, 1);
      start_window(100, n);
      check(cxl ? "R8 early cancel window" : "R6 busy window", n, cxl ? 4 : LAT + 3);
      for (int w = 0; w < 3; w++) begin
        rd(8'(8'h80 + 4 * w), v);
        check(cxl ? "R8 cancelled response" : "R7 response", v, exp_word(w, VEC[i][15:0], rc));
      end
      rd(8'h08, v); check("R8 cancel held", v, {31'b0, cxl});
      rd(8'h14, v); check("R10 int status", v, 1);
      check("R10 irq", {31'b0, irq}, 1);
      @(negedge clk);
      wr(8'h14, 1);
      check("R10 irq cleared", {31'b0, irq}, 0);
      wr(8'h08, 0);
    end

    // R8 cancel while running
    @(negedge clk);
    wr(8'h80, 32'h0000_7711);
    wr(8'h0C, 1);
    repeat (5) @(negedge clk);
    wr(8'h08, 1);
    start_window(100, n);
    check("R8 mid-run stop", {31'b0, n <= 5}, 1);
    rd(8'h84, v); check("R8 mid-run rc", v, exp_word(1, 16'h7711, RCC));
    rd(8'h88, v); check("R8 mid-run rc tail", v, exp_word(2, 16'h7711, RCC));
    rd(8'h08, v); check("R8 cancel held", v, 1);
    @(negedge clk);
    wr(8'h08, 0);

    // R4 go-idle deferred by a running command
    wr(8'h80, 32'h0000_0042);
    wr(8'h0C, 1);
    wr(8'h00, 2);
    repeat (5) @(negedge clk);
    rd(8'h00, v); check("R4 idle pending", v, 2);
    rd(8'h04, v); check("R4 not yet idle", v, 0);
    start_window(100, n);
    wait_req_clear(20, n);
    rd(8'h00, v); check("R4 idle done", v, 0);
    rd(8'h04, v); check("R4 idle status", v, 2);

    // R5 command-ready overtakes pending go-idle
    @(negedge clk);
    wr(8'h00, 1);
    wait_req_clear(20, n);
    @(negedge clk);
    wr(8'h00, 2);
    wr(8'h00, 1);
    wait_req_clear(20, n);
    rd(8'h00, v); check("R5 request bits", v, 0);
    rd(8'h04, v); check("R5 ends ready", v, 0);

    finish_run();
  end
endmodule